// File: doc/BRIEF.md
# Instruction-Stream Communication Rewriter

This block sits between one soft processor and the instruction and data memories of the task that processor is running. Every instruction word fetched for the processor passes through it. Point-to-point stream send and receive instructions carry a task number instead of a physical link number. The block turns them into ordinary memory instructions: a send becomes a store-word and a receive becomes a load-word, with the task number as the address. Tasks can therefore exchange data by ID, whatever processor each happens to run on.

Once it has delivered a rewritten word, the block detaches the task's memories from the processor. No further instruction words are delivered and data-memory strobes are suppressed. The processor's next data access is steered to a shared inter-task message store. The store word always retires, so the processor itself never stalls. If the message store is not ready, the block holds the request itself, keeping the latched address and write data, until the store accepts it. The task stays blocked during that wait, while the processor stays free to run other code such as a virtualization procedure. The memories are re-attached on the cycle after the store signals ready.

A bypass input lets every instruction through untouched, for processors that are not running under virtualization.

Top module: `stream_rewriter`

## Requirements
- R1: While attached and not in bypass, an instruction word whose opcode (bits [31:26]) is neither 6'h3B nor 6'h3A is delivered to the processor unchanged, with its valid flag, in the same cycle it is fetched.
- R2: A stream-send word (opcode 6'h3B) is delivered as a store-word (opcode 6'h2B): bits [25:21] are kept, bits [20:16] become 0, and bits [15:0] become the task ID taken from bits [TID_W-1:0] (4 bits by default), zero-extended.
- R3: A stream-receive word (opcode 6'h3A) is delivered as a load-word (opcode 6'h23), with the same field rules as R2.
- R4: With bypass high, every fetched word is delivered unaltered, and the memories stay attached.
- R5: From the cycle after a rewritten word is delivered until the transfer completes, `mem_attached_o` is low, `proc_instr_valid_o` is low, and `dmem_we_o`/`dmem_re_o` are low. In the first such cycle, the processor's store or load is steered to the message store: `msg_addr_o` is the processor address, and on a store `msg_wdata_o` is the processor write data.
- R6: When the message store is ready in that first cycle, the memories are re-attached on the next cycle, so the non-blocked transfer spans two cycles.
- R7: A blocked store keeps `msg_wr_o` high with unchanged address and data until `msg_ready_i` is seen, even after the processor drops its store. The memories re-attach on the cycle after that.
- R8: A blocked receive keeps `msg_rd_o` high with unchanged address until `msg_ready_i`. During the ready cycle, `proc_rdata_o` equals `msg_rdata_i`, and the memories re-attach on the next cycle.
- R9: While attached, processor data accesses go to the task data memory: strobes, address and data are passed through, `proc_rdata_o` is `dmem_rdata_i`, and no message-store request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bypass_i | input | 1 | Pass all instructions unaltered |
| imem_valid_i | input | 1 | Instruction word from task memory is valid |
| imem_rdata_i | input | 32 | Instruction word from task memory |
| proc_instr_valid_o | output | 1 | Instruction word to processor is valid |
| proc_instr_o | output | 32 | Instruction word to processor |
| proc_addr_i | input | AW | Processor data address |
| proc_wdata_i | input | DW | Processor store data |
| proc_we_i | input | 1 | Processor store strobe |
| proc_re_i | input | 1 | Processor load strobe |
| proc_rdata_o | output | DW | Load data to processor |
| dmem_addr_o | output | AW | Task data memory address |
| dmem_wdata_o | output | DW | Task data memory write data |
| dmem_we_o | output | 1 | Task data memory write strobe |
| dmem_re_o | output | 1 | Task data memory read strobe |
| dmem_rdata_i | input | DW | Task data memory read data |
| msg_addr_o | output | TID_W | Message store task address |
| msg_wdata_o | output | DW | Message store write data |
| msg_wr_o | output | 1 | Message store write request |
| msg_rd_o | output | 1 | Message store read request |
| msg_ready_i | input | 1 | Message store accepts the write or has read data |
| msg_rdata_i | input | DW | Message store read data |
| mem_attached_o | output | 1 | Task memories connected to processor |

## Verification
The assertions assume the processor behaves as the rewritten word asks. That means exactly one store or load, in the cycle after a rewritten send or receive is delivered, with the task ID as its address. They also assume `msg_ready_i` is only meaningful while a request is raised. The stimulus follows every rewritten word with exactly that access and then releases the strobes. Ready delays are drawn at random from zero to three cycles. No processor access is driven in the cycle after a pass-through word. Bypass is only changed on instruction boundaries, never during a transfer.

// File: rtl/stream_rewriter_pkg.sv
package stream_rewriter_pkg;
    localparam int IW = 32;
    localparam logic [5:0] OP_SEND = 6'h3B;
    localparam logic [5:0] OP_RECV = 6'h3A;
    localparam logic [5:0] OP_STW  = 6'h2B;
    localparam logic [5:0] OP_LDW  = 6'h23;

    typedef enum logic [1:0] {
        XS_IDLE   = 2'd0,
        XS_ISSUED = 2'd1,
        XS_HOLD   = 2'd2
    } xstate_e;
endpackage

// File: rtl/sr_instr_rewrite.sv
module sr_instr_rewrite
    import stream_rewriter_pkg::*;
#(
    parameter int TID_W = 4
) (
    input  logic [IW-1:0]    instr_i,
    input  logic             valid_i,
    input  logic             bypass_i,
    input  logic             attached_i,
    output logic [IW-1:0]    instr_o,
    output logic             valid_o,
    output logic             hit_o,
    output logic             hit_rd_o,
    output logic [TID_W-1:0] hit_tid_o
);
    localparam int PAD_W = 16 - TID_W;

    logic [5:0] op;
    logic       is_send;
    logic       is_recv;

    always_comb begin
        op        = instr_i[31:26];
        is_send   = (op == OP_SEND);
        is_recv   = (op == OP_RECV);
        hit_tid_o = instr_i[TID_W-1:0];
        hit_rd_o  = is_recv;
        valid_o   = valid_i & attached_i;
        hit_o     = valid_o & ~bypass_i & (is_send | is_recv);
        instr_o   = instr_i;
        if (!bypass_i && (is_send || is_recv)) begin
            instr_o = {(is_send ? OP_STW : OP_LDW), instr_i[25:21], 5'd0,
                       {PAD_W{1'b0}}, instr_i[TID_W-1:0]};
        end
        if (!attached_i) begin
            instr_o = '0;
        end
    end
endmodule

// File: rtl/sr_xfer_ctrl.sv
module sr_xfer_ctrl
    import stream_rewriter_pkg::*;
#(
    parameter int TID_W = 4,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             hit_rd_i,
    input  logic [TID_W-1:0] hit_tid_i,
    input  logic [AW-1:0]    proc_addr_i,
    input  logic [DW-1:0]    proc_wdata_i,
    input  logic             proc_we_i,
    input  logic             proc_re_i,
    input  logic             msg_ready_i,
    output logic             attached_o,
    output logic             msg_wr_o,
    output logic             msg_rd_o,
    output logic [TID_W-1:0] msg_addr_o,
    output logic [DW-1:0]    msg_wdata_o
);
    typedef struct packed {
        xstate_e          st;
        logic             rd;
        logic [TID_W-1:0] tid;
        logic [DW-1:0]    wd;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic acc;

    always_comb begin
        ctl_d       = ctl_q;
        attached_o  = (ctl_q.st == XS_IDLE);
        msg_wr_o    = 1'b0;
        msg_rd_o    = 1'b0;
        msg_addr_o  = ctl_q.tid;
        msg_wdata_o = ctl_q.wd;
        acc         = 1'b0;
        case (ctl_q.st)
            XS_IDLE: begin
                if (hit_i) begin
                    ctl_d.st  = XS_ISSUED;
                    ctl_d.rd  = hit_rd_i;
                    ctl_d.tid = hit_tid_i;
                end
            end
            XS_ISSUED: begin
                acc         = ctl_q.rd ? proc_re_i : proc_we_i;
                msg_wr_o    = proc_we_i & ~ctl_q.rd;
                msg_rd_o    = proc_re_i & ctl_q.rd;
                msg_addr_o  = proc_addr_i[TID_W-1:0];
                msg_wdata_o = proc_wdata_i;
                if (acc) begin
                    ctl_d.wd  = proc_wdata_i;
                    ctl_d.tid = proc_addr_i[TID_W-1:0];
                    ctl_d.st  = msg_ready_i ? XS_IDLE : XS_HOLD;
                end
            end
            XS_HOLD: begin
                msg_wr_o = ~ctl_q.rd;
                msg_rd_o = ctl_q.rd;
                if (msg_ready_i) begin
                    ctl_d.st = XS_IDLE;
                end
            end
            default: ctl_d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: XS_IDLE, rd: 1'b0, tid: '0, wd: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/sr_data_steer.sv
module sr_data_steer #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          attached_i,
    input  logic [AW-1:0] proc_addr_i,
    input  logic [DW-1:0] proc_wdata_i,
    input  logic          proc_we_i,
    input  logic          proc_re_i,
    output logic [DW-1:0] proc_rdata_o,
    output logic [AW-1:0] dmem_addr_o,
    output logic [DW-1:0] dmem_wdata_o,
    output logic          dmem_we_o,
    output logic          dmem_re_o,
    input  logic [DW-1:0] dmem_rdata_i,
    input  logic [DW-1:0] msg_rdata_i
);
    always_comb begin
        dmem_addr_o  = proc_addr_i;
        dmem_wdata_o = proc_wdata_i;
        dmem_we_o    = proc_we_i & attached_i;
        dmem_re_o    = proc_re_i & attached_i;
        proc_rdata_o = attached_i ? dmem_rdata_i : msg_rdata_i;
    end
endmodule

// File: rtl/stream_rewriter.sv
module stream_rewriter
    import stream_rewriter_pkg::*;
#(
    parameter int TID_W = 4,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass_i,
    input  logic             imem_valid_i,
    input  logic [31:0]      imem_rdata_i,
    output logic             proc_instr_valid_o,
    output logic [31:0]      proc_instr_o,
    input  logic [AW-1:0]    proc_addr_i,
    input  logic [DW-1:0]    proc_wdata_i,
    input  logic             proc_we_i,
    input  logic             proc_re_i,
    output logic [DW-1:0]    proc_rdata_o,
    output logic [AW-1:0]    dmem_addr_o,
    output logic [DW-1:0]    dmem_wdata_o,
    output logic             dmem_we_o,
    output logic             dmem_re_o,
    input  logic [DW-1:0]    dmem_rdata_i,
    output logic [TID_W-1:0] msg_addr_o,
    output logic [DW-1:0]    msg_wdata_o,
    output logic             msg_wr_o,
    output logic             msg_rd_o,
    input  logic             msg_ready_i,
    input  logic [DW-1:0]    msg_rdata_i,
    output logic             mem_attached_o
);
    logic             attached;
    logic             hit;
    logic             hit_rd;
    logic [TID_W-1:0] hit_tid;

    sr_instr_rewrite #(.TID_W(TID_W)) u_rewrite (
        .instr_i    (imem_rdata_i),
        .valid_i    (imem_valid_i),
        .bypass_i   (bypass_i),
        .attached_i (attached),
        .instr_o    (proc_instr_o),
        .valid_o    (proc_instr_valid_o),
        .hit_o      (hit),
        .hit_rd_o   (hit_rd),
        .hit_tid_o  (hit_tid)
    );

    sr_xfer_ctrl #(.TID_W(TID_W), .AW(AW), .DW(DW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_i        (hit),
        .hit_rd_i     (hit_rd),
        .hit_tid_i    (hit_tid),
        .proc_addr_i  (proc_addr_i),
        .proc_wdata_i (proc_wdata_i),
        .proc_we_i    (proc_we_i),
        .proc_re_i    (proc_re_i),
        .msg_ready_i  (msg_ready_i),
        .attached_o   (attached),
        .msg_wr_o     (msg_wr_o),
        .msg_rd_o     (msg_rd_o),
        .msg_addr_o   (msg_addr_o),
        .msg_wdata_o  (msg_wdata_o)
    );

    sr_data_steer #(.AW(AW), .DW(DW)) u_steer (
        .attached_i   (attached),
        .proc_addr_i  (proc_addr_i),
        .proc_wdata_i (proc_wdata_i),
        .proc_we_i    (proc_we_i),
        .proc_re_i    (proc_re_i),
        .proc_rdata_o (proc_rdata_o),
        .dmem_addr_o  (dmem_addr_o),
        .dmem_wdata_o (dmem_wdata_o),
        .dmem_we_o    (dmem_we_o),
        .dmem_re_o    (dmem_re_o),
        .dmem_rdata_i (dmem_rdata_i),
        .msg_rdata_i  (msg_rdata_i)
    );

    assign mem_attached_o = attached;
endmodule

// File: rtl/stream_rewriter_checker.sv
module stream_rewriter_checker
    import stream_rewriter_pkg::*;
#(
    parameter int TID_W = 4,
    parameter int DW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bypass_i,
    input logic [31:0]      imem_rdata_i,
    input logic             proc_instr_valid_o,
    input logic [31:0]      proc_instr_o,
    input logic             dmem_we_o,
    input logic             dmem_re_o,
    input logic [TID_W-1:0] msg_addr_o,
    input logic [DW-1:0]    msg_wdata_o,
    input logic             msg_wr_o,
    input logic             msg_rd_o,
    input logic             msg_ready_i,
    input logic             mem_attached_o
);
    p_detach_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_attached_o |-> (!proc_instr_valid_o && !dmem_we_o && !dmem_re_o));

    p_send_detaches_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_instr_valid_o && !bypass_i && imem_rdata_i[31:26] == OP_SEND)
        |=> !mem_attached_o);

    p_bypass_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_i && proc_instr_valid_o) |-> (proc_instr_o == imem_rdata_i));

    p_hold_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_wr_o && !msg_ready_i) |=>
        (msg_wr_o && $stable(msg_wdata_o) && $stable(msg_addr_o)));

    p_hold_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_rd_o && !msg_ready_i) |=> (msg_rd_o && $stable(msg_addr_o)));

    p_reattach_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((msg_wr_o || msg_rd_o) && msg_ready_i) |=> mem_attached_o);

    p_attached_no_msg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_attached_o |-> (!msg_wr_o && !msg_rd_o));
endmodule

bind stream_rewriter stream_rewriter_checker #(.TID_W(TID_W), .DW(DW)) u_checker (
    .clk                (clk),
    .rst_n              (rst_n),
    .bypass_i           (bypass_i),
    .imem_rdata_i       (imem_rdata_i),
    .proc_instr_valid_o (proc_instr_valid_o),
    .proc_instr_o       (proc_instr_o),
    .dmem_we_o          (dmem_we_o),
    .dmem_re_o          (dmem_re_o),
    .msg_addr_o         (msg_addr_o),
    .msg_wdata_o        (msg_wdata_o),
    .msg_wr_o           (msg_wr_o),
    .msg_rd_o           (msg_rd_o),
    .msg_ready_i        (msg_ready_i),
    .mem_attached_o     (mem_attached_o)
);

// File: tb/stream_rewriter_bench.sv
module stream_rewriter_bench;
    localparam int CLK_P = 10;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bypass_i = 1'b0;
    logic          imem_valid_i = 1'b0;
    logic [31:0]   imem_rdata_i = '0;
    logic          proc_instr_valid_o;
    logic [31:0]   proc_instr_o;
    logic [AW-1:0] proc_addr_i = '0;
    logic [DW-1:0] proc_wdata_i = '0;
    logic          proc_we_i = 1'b0;
    logic          proc_re_i = 1'b0;
    logic [DW-1:0] proc_rdata_o;
    logic [AW-1:0] dmem_addr_o;
    logic [DW-1:0] dmem_wdata_o;
    logic          dmem_we_o;
    logic          dmem_re_o;
    logic [DW-1:0] dmem_rdata_i = '0;
    logic [TW-1:0] msg_addr_o;
    logic [DW-1:0] msg_wdata_o;
    logic          msg_wr_o;
    logic          msg_rd_o;
    logic          msg_ready_i = 1'b0;
    logic [DW-1:0] msg_rdata_i = '0;
    logic          mem_attached_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    stream_rewriter #(.TID_W(TW), .AW(AW), .DW(DW)) u_stream_rewriter (
        .clk(clk), .rst_n(rst_n), .bypass_i(bypass_i),
        .imem_valid_i(imem_valid_i), .imem_rdata_i(imem_rdata_i),
        .proc_instr_valid_o(proc_instr_valid_o), .proc_instr_o(proc_instr_o),
        .proc_addr_i(proc_addr_i), .proc_wdata_i(proc_wdata_i),
        .proc_we_i(proc_we_i), .proc_re_i(proc_re_i), .proc_rdata_o(proc_rdata_o),
        .dmem_addr_o(dmem_addr_o), .dmem_wdata_o(dmem_wdata_o),
        .dmem_we_o(dmem_we_o), .dmem_re_o(dmem_re_o), .dmem_rdata_i(dmem_rdata_i),
        .msg_addr_o(msg_addr_o), .msg_wdata_o(msg_wdata_o),
        .msg_wr_o(msg_wr_o), .msg_rd_o(msg_rd_o), .msg_ready_i(msg_ready_i),
        .msg_rdata_i(msg_rdata_i), .mem_attached_o(mem_attached_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [31:0] w, input bit byp);
        if (!byp && w[31:26] == 6'h3B) return {6'h2B, w[25:21], 5'd0, 12'd0, w[3:0]};
        if (!byp && w[31:26] == 6'h3A) return {6'h23, w[25:21], 5'd0, 12'd0, w[3:0]};
        return w;
    endfunction

    function automatic string word_req(input logic [31:0] w, input bit byp);
        if (byp) return "R4";
        if (w[31:26] == 6'h3B) return "R2";
        if (w[31:26] == 6'h3A) return "R3";
        return "R1";
    endfunction

    // One fetched word; for a rewritten send/receive, perform the access with wait_n ready delay
    task automatic do_instr(input logic [31:0] w, input bit byp, input int wait_n);
        bit          strm;
        bit          is_rd;
        logic [3:0]  tid;
        logic [31:0] sd;
        logic [31:0] rdv;
        strm  = !byp && (w[31:26] == 6'h3B || w[31:26] == 6'h3A);
        is_rd = (w[31:26] == 6'h3A);
        tid   = w[3:0];
        @(negedge clk);
        imem_valid_i = 1'b1; imem_rdata_i = w; bypass_i = byp;
        proc_we_i = 1'b0; proc_re_i = 1'b0; msg_ready_i = 1'b0;
        #1;
        chk(proc_instr_o == exp_word(w, byp), word_req(w, byp), proc_instr_o, exp_word(w, byp));
        chk(proc_instr_valid_o == 1'b1, word_req(w, byp), {31'd0, proc_instr_valid_o}, 32'd1);
        @(negedge clk);
        if (!strm) begin
            #1;
            chk(mem_attached_o == 1'b1, byp ? "R4" : "R1", {31'd0, mem_attached_o}, 32'd1);
            return;
        end
        sd  = $urandom;
        rdv = $urandom;
        proc_addr_i  = {12'd0, tid};
        proc_wdata_i = sd;
        proc_we_i    = !is_rd;
        proc_re_i    = is_rd;
        msg_rdata_i  = rdv;
        msg_ready_i  = (wait_n == 0);
        #1;
        chk(mem_attached_o == 1'b0 && proc_instr_valid_o == 1'b0 && !dmem_we_o && !dmem_re_o,
            "R5", {28'd0, mem_attached_o, proc_instr_valid_o, dmem_we_o, dmem_re_o}, 32'd0);
        chk(msg_wr_o == !is_rd && msg_rd_o == is_rd && msg_addr_o == tid, "R5",
            {26'd0, msg_wr_o, msg_rd_o, msg_addr_o}, {26'd0, !is_rd, is_rd, tid});
        if (!is_rd) chk(msg_wdata_o == sd, "R5", msg_wdata_o, sd);
        if (is_rd && wait_n == 0) chk(proc_rdata_o == rdv, "R8", proc_rdata_o, rdv);
        for (int i = 1; i <= wait_n; i++) begin
            @(negedge clk);
            proc_we_i = 1'b0; proc_re_i = 1'b0;
            proc_wdata_i = $urandom; proc_addr_i = $urandom;
            msg_ready_i = (i == wait_n);
            #1;
            chk(msg_wr_o == !is_rd && msg_rd_o == is_rd && msg_addr_o == tid && !mem_attached_o,
                is_rd ? "R8" : "R7", {25'd0, mem_attached_o, msg_wr_o, msg_rd_o, msg_addr_o},
                {26'd0, !is_rd, is_rd, tid});
            if (!is_rd) chk(msg_wdata_o == sd, "R7", msg_wdata_o, sd);
            if (is_rd && i == wait_n) chk(proc_rdata_o == rdv, "R8", proc_rdata_o, rdv);
        end
        @(negedge clk);
        msg_ready_i = 1'b0; proc_we_i = 1'b0; proc_re_i = 1'b0; imem_valid_i = 1'b0;
        #1;
        chk(mem_attached_o == 1'b1, (wait_n == 0) ? "R6" : (is_rd ? "R8" : "R7"),
            {31'd0, mem_attached_o}, 32'd1);
    endtask

    // R9: attached data accesses go to the task memory
    task automatic idle_access(input bit wr);
        logic [15:0] a;
        logic [31:0] d;
        logic [31:0] r;
        a = $urandom; d = $urandom; r = $urandom;
        @(negedge clk);
        imem_valid_i = 1'b0;
        proc_addr_i = a; proc_wdata_i = d; proc_we_i = wr; proc_re_i = !wr;
        dmem_rdata_i = r; msg_rdata_i = ~r;
        #1;
        chk(dmem_we_o == wr && dmem_re_o == !wr && !msg_wr_o && !msg_rd_o, "R9",
            {28'd0, dmem_we_o, dmem_re_o, msg_wr_o, msg_rd_o}, {28'd0, wr, !wr, 2'b00});
        chk(dmem_addr_o == a && dmem_wdata_o == d, "R9", {dmem_addr_o, 16'd0}, {a, 16'd0});
        chk(proc_rdata_o == r, "R9", proc_rdata_o, r);
        @(negedge clk);
        proc_we_i = 1'b0; proc_re_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        int          kind;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        #1;
        chk(mem_attached_o == 1'b1 && !msg_wr_o && !msg_rd_o && !proc_instr_valid_o, "R9",
            {28'd0, mem_attached_o, msg_wr_o, msg_rd_o, proc_instr_valid_o}, 32'd8);
        rst_n = 1'b1;
        // directed corners
        do_instr(32'hEC00_0007, 1'b0, 0);   // send: R2 with rd=0, tid 7 -> R6
        do_instr({6'h3B, 5'd31, 5'd9, 16'hFFFF}, 1'b0, 3); // R2 junk fields, blocked R7
        do_instr({6'h3A, 5'd4, 5'd3, 16'h0A0C}, 1'b0, 0);  // R3 non-blocked
        do_instr({6'h3A, 5'd17, 5'd0, 16'h000F}, 1'b0, 2); // R3 blocked R8
        do_instr({6'h3B, 5'd2, 5'd1, 16'h0005}, 1'b1, 0);  // R4 bypass send
        do_instr({6'h2B, 5'd2, 5'd1, 16'h1234}, 1'b0, 0);  // R1 real store passes
        idle_access(1'b1);
        idle_access(1'b0);
        // constrained random mix
        for (int k = 0; k < 300; k++) begin
            w = $urandom;
            kind = $urandom_range(0, 7);
            if (kind < 3) w[31:26] = 6'h3B;
            else if (kind < 5) w[31:26] = 6'h3A;
            do_instr(w, ($urandom_range(0, 7) == 0), $urandom_range(0, 3));
            if (k % 16 == 0) idle_access($urandom_range(0, 1) == 1);
        end
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule